// File: doc/BRIEF.md
# Shared-Address Divider/Control Register Pair

This block places two 8-bit configuration registers behind a single bus address. One holds the upper byte of a baud-rate divider. The other holds frame-control settings. The block sits on a simple single-cycle register bus. Each cycle, an address-match input qualifies a read strobe, a write strobe and the write data. Read data comes back combinationally in the same cycle.

Writes are steered by the data itself. The most significant bit of the written byte chooses the destination. A clear bit loads the whole byte into the divider register. A set bit loads the lower seven bits into the control register.

Reads are steered by timing. A read that was not preceded by a read of this address in the immediately previous clock cycle returns the divider register. A read that directly follows such a read returns the control register, with its top bit forced to one. Software therefore fetches the control value with two reads issued back to back.

Top module: `shr_pair_reg`

## Requirements
- R1: A qualified write (`bus_sel` and `bus_wr` high) with `bus_wdata[7]` = 0 loads all 8 bits into the divider register at the next clock edge and leaves the control register unchanged.
- R2: A qualified write with `bus_wdata[7]` = 1 loads `bus_wdata[6:0]` into the control register at the next clock edge and leaves the divider register unchanged.
- R3: A qualified read (`bus_sel` and `bus_rd` high) whose previous clock cycle held no qualified read returns the divider register on `bus_rdata` in the same cycle.
- R4: A qualified read whose previous cycle also held a qualified read returns `{1'b1, control[6:0]}`. This holds for every read after the first in an unbroken run of reads, so a third consecutive read again returns the control value.
- R5: Any cycle without a qualified read breaks the sequence, so the next read returns the divider register. This covers an idle cycle, a write cycle, and a read strobe without address match.
- R6: Read and write strobes with `bus_sel` low change neither register.
- R7: `bus_rdata` is all zeros in any cycle without a qualified read.
- R8: After reset, the divider register holds `DIV_RESET`, the control register holds `CTRL_RESET`, and the first read returns the divider register.
- R9: When a qualified read and a qualified write occur in the same cycle, the read returns the value held before that cycle. The write is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Address match for the shared location |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data; top bit selects the destination |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |

## Verification
The bench builds the block with `DATA_W` = 8 and nonzero reset values: `DIV_RESET` = 8'h03 and `CTRL_RESET` = 7'h06. With these values, the reset check can tell a loaded register apart from a cleared one. It also confirms that the forced top bit on a control read is added by the read path and is not stored. Directed sequences cover the following cases: two and three reads in a row; runs broken by an idle cycle, by a write, and by an unmatched read; unmatched writes of both select values; and a read and a write in the same cycle.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_CTRL = 2'd2
    } rd_src_e;

endpackage

// File: rtl/shr_wr_decode.sv
module shr_wr_decode #(
    parameter int DATA_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ld_div,
    output logic              ld_ctrl
);
    localparam int SEL_BIT = DATA_W - 1;

    logic wr_hit;

    always_comb begin
        wr_hit  = bus_sel & bus_wr;
        ld_div  = wr_hit & ~bus_wdata[SEL_BIT];
        ld_ctrl = wr_hit &  bus_wdata[SEL_BIT];
    end
endmodule

// File: rtl/shr_rd_track.sv
module shr_rd_track
    import shr_pkg::*;
(
    input  logic    rd_hit,
    input  logic    prev_rd,
    output rd_src_e rd_src
);
    always_comb begin
        if (!rd_hit) begin
            rd_src = SRC_NONE;
        end else if (prev_rd) begin
            rd_src = SRC_CTRL;
        end else begin
            rd_src = SRC_DIV;
        end
    end
endmodule

// File: rtl/shr_rd_mux.sv
module shr_rd_mux
    import shr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rd_src_e           rd_src,
    input  logic [DATA_W-1:0] div_val,
    input  logic [DATA_W-2:0] ctrl_val,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (rd_src)
            SRC_DIV:  rdata = div_val;
            SRC_CTRL: rdata = {1'b1, ctrl_val};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/shr_pair_reg.sv
module shr_pair_reg
    import shr_pkg::*;
#(
    parameter int                  DATA_W     = 8,
    parameter logic [DATA_W-1:0]   DIV_RESET  = '0,
    parameter logic [DATA_W-2:0]   CTRL_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int CTRL_W = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] div;
        logic [CTRL_W-1:0] ctrl;
        logic              prev_rd;
    } state_t;

    state_t  state_d, state_q;
    logic    ld_div, ld_ctrl;
    logic    rd_hit;
    rd_src_e rd_src;

    // Plain views of the state for the bound checker
    logic [DATA_W-1:0] div_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              prev_rd_q;

    shr_wr_decode #(.DATA_W(DATA_W)) u_wr (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .ld_div    (ld_div),
        .ld_ctrl   (ld_ctrl)
    );

    shr_rd_track u_track (
        .rd_hit  (rd_hit),
        .prev_rd (state_q.prev_rd),
        .rd_src  (rd_src)
    );

    shr_rd_mux #(.DATA_W(DATA_W)) u_mux (
        .rd_src   (rd_src),
        .div_val  (state_q.div),
        .ctrl_val (state_q.ctrl),
        .rdata    (bus_rdata)
    );

    always_comb begin
        rd_hit    = bus_sel & bus_rd;
        div_q     = state_q.div;
        ctrl_q    = state_q.ctrl;
        prev_rd_q = state_q.prev_rd;
    end

    always_comb begin
        state_d = state_q;
        if (ld_div) begin
            state_d.div = bus_wdata;
        end
        if (ld_ctrl) begin
            state_d.ctrl = bus_wdata[CTRL_W-1:0];
        end
        state_d.prev_rd = rd_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.div     <= DIV_RESET;
            state_q.ctrl    <= CTRL_RESET;
            state_q.prev_rd <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/shr_pair_chk.sv
module shr_pair_chk #(
    parameter int DATA_W = 8,
    parameter int CTRL_W = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] div_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              prev_rd_q
);
    a_r1_div_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_wdata[DATA_W-1]) |=>
            (div_q == $past(bus_wdata)) && $stable(ctrl_q));

    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_wdata[DATA_W-1]) |=>
            (ctrl_q == $past(bus_wdata[CTRL_W-1:0])) && $stable(div_q));

    a_r3_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && !prev_rd_q) |-> (bus_rdata == div_q));

    a_r4_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && prev_rd_q) |-> (bus_rdata == {1'b1, ctrl_q}));

    a_r5_break: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_rd) |=> !prev_rd_q);

    a_r6_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(div_q) && $stable(ctrl_q));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_rd) |-> (bus_rdata == '0));
endmodule

bind shr_pair_reg shr_pair_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .div_q     (div_q),
    .ctrl_q    (ctrl_q),
    .prev_rd_q (prev_rd_q)
);

// File: tb/sim_shr_pair_reg.sv
module sim_shr_pair_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shr_pair_reg #(
        .DATA_W     (8),
        .DIV_RESET  (8'h03),
        .CTRL_RESET (7'h06)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // One bus cycle: drive at falling edge, optionally check read data, wait for rising edge
    task automatic step(input logic s, input logic r, input logic w,
                        input logic [7:0] d, input bit chk,
                        input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel   = s;
        bus_rd    = r;
        bus_wr    = w;
        bus_wdata = d;
        #1;
        if (chk) begin
            checks++;
            if (bus_rdata !== exp) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", req, bus_rdata, exp);
            end
        end
        @(posedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, "R7");
    endtask

    task automatic t_reset();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h03, "R8");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h86, "R8");
        idle();
    endtask

    task automatic t_write_div();
        step(1'b1, 1'b0, 1'b1, 8'h2C, 1'b1, 8'h00, "R7");
        idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h2C, "R1");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h86, "R1");
        idle();
    endtask

    task automatic t_write_ctrl();
        step(1'b1, 1'b0, 1'b1, 8'hD5, 1'b0, 8'h00, "R2");
        idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h2C, "R2");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hD5, "R2");
        idle();
    endtask

    task automatic t_chain();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h2C, "R3");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hD5, "R4");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hD5, "R4");
        idle();
    endtask

    task automatic t_break();
        // idle cycle in between
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h2C, "R5");
        idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h2C, "R5");
        // unmatched read in between
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00, "R7");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h2C, "R5");
        // write in between
        step(1'b1, 1'b0, 1'b1, 8'h11, 1'b1, 8'h00, "R7");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h11, "R5");
        idle();
    endtask

    task automatic t_unmatched();
        step(1'b0, 1'b0, 1'b1, 8'h77, 1'b1, 8'h00, "R6");
        step(1'b0, 1'b0, 1'b1, 8'hF0, 1'b1, 8'h00, "R6");
        idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h11, "R6");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hD5, "R6");
        idle();
    endtask

    task automatic t_same_cycle();
        step(1'b1, 1'b1, 1'b1, 8'h40, 1'b1, 8'h11, "R9");
        idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h40, "R9");
        step(1'b1, 1'b1, 1'b1, 8'h9A, 1'b1, 8'hD5, "R9");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h9A, "R9");
        idle();
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: rdata=%h expected=finish", bus_rdata);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        checks++;
        if (bus_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R7: rdata=%h expected=%h", bus_rdata, 8'h00);
        end
        rst_n = 1'b1;
        t_reset();
        t_write_div();
        t_write_ctrl();
        t_chain();
        t_break();
        t_unmatched();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule